// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps in-flight instructions of an out-of-order core in program order. Each issued instruction takes one entry at the tail of a circular buffer. The index of that entry is the tag that waiting consumers record. Execution units later return results on a shared result bus, each result marked with its tag and arriving in any order. The buffer holds each value until the instruction reaches the head. Meanwhile two operand lookup ports can read the value straight from the buffer.

Retirement is strictly in order, at most one entry per cycle, and only when the head entry has its result. A register operation writes the register file at retirement. A store hands its address and data to the store path, which can apply back-pressure. A branch whose result is flagged as mispredicted removes itself and every younger entry. It also drives a one-cycle redirect carrying the correct restart address. A per-register producer table records which entry will write each architected register, so a lookup can report whether to use the register file or the buffer.

Stream rules: the allocate port moves an instruction on a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` is low when the buffer is full, and in the cycle a redirect is driven. The store port offers `st_valid` and keeps address and data unchanged until `st_ready` is seen high. Nothing younger retires while a store waits. The result bus has no back-pressure: every `res_valid` pulse is taken.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, and `cm_reg_we`, `st_valid`, `redir_valid` and both lookup `busy` outputs are 0.
- R2: Every accepted allocation returns `alloc_tag` equal to the tail index. Tags advance by one per accepted instruction, modulo DEPTH, in program order. A redirect does not reset this sequence. Kind encoding on `alloc_kind`: 2'b00 register operation (destination low bits name the register), 2'b01 store (destination is a memory address), 2'b10 branch.
- R3: After DEPTH allocations without retirement, `alloc_ready` is 0. An `alloc_valid` held during that time adds no entry and does not mark any register as pending.
- R4: A `res_valid` pulse with `res_tag` stores `res_value` and `res_mispred` in that entry and marks it complete. Results may arrive in any order.
- R5: The head entry retires only when it is complete, one entry per cycle, in allocation order. At the earliest it retires in the cycle after its result arrives. A register operation at retirement drives `cm_reg_we` high for one cycle, with `cm_reg_idx` set to the destination's low bits and `cm_reg_data` set to its value.
- R6: A lookup of a register with a pending producer reports `busy`=1 and the producer's tag. It also reports `ready`=1 together with the value once that producer is complete, even though it has not yet retired.
- R7: A register's lookup `busy` drops after its youngest producer retires. If an older producer retires while a younger one is pending, `busy` stays 1 with the younger tag.
- R8: A complete store at the head drives `st_valid` with `st_addr` equal to its destination and `st_data` equal to its value. These stay stable while `st_ready` is 0, and no younger entry retires until the store is accepted.
- R9: A complete branch with `res_mispred`=0 retires without a redirect.
- R10: A complete branch with `res_mispred`=1 at the head drives `redir_valid` for one cycle, with `redir_pc` set to its value, and holds `alloc_ready` at 0 in that cycle. On the next cycle the buffer is empty and no lookup reports `busy`. Younger entries never retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Instruction offered for allocation |
| alloc_ready | output | 1 | Buffer can accept an instruction |
| alloc_kind | input | 2 | Instruction kind (00 reg op, 01 store, 10 branch) |
| alloc_dest | input | DEST_W | Register number or store address |
| alloc_tag | output | IDX_W | Tag of the entry being allocated |
| res_valid | input | 1 | Result present on the bus |
| res_tag | input | IDX_W | Entry the result belongs to |
| res_value | input | DATA_W | Result, store data or branch restart address |
| res_mispred | input | 1 | Branch outcome differs from prediction |
| lk0_reg | input | REG_W | Register looked up on port 0 |
| lk0_busy | output | 1 | Port 0 register has a pending producer |
| lk0_tag | output | IDX_W | Port 0 producer tag |
| lk0_ready | output | 1 | Port 0 producer value is available |
| lk0_value | output | DATA_W | Port 0 value from the buffer |
| lk1_reg | input | REG_W | Register looked up on port 1 |
| lk1_busy | output | 1 | Port 1 register has a pending producer |
| lk1_tag | output | IDX_W | Port 1 producer tag |
| lk1_ready | output | 1 | Port 1 producer value is available |
| lk1_value | output | DATA_W | Port 1 value from the buffer |
| cm_reg_we | output | 1 | Register file write at retirement |
| cm_reg_idx | output | REG_W | Register written |
| cm_reg_data | output | DATA_W | Value written |
| st_valid | output | 1 | Retiring store offered |
| st_ready | input | 1 | Store path accepts the store |
| st_addr | output | DEST_W | Store address |
| st_data | output | DATA_W | Store data |
| redir_valid | output | 1 | Mispredicted branch flush and fetch redirect |
| redir_pc | output | DATA_W | Correct restart address |

## Verification
A corrupted head or tail pointer shows up within a few cycles. Register writes come out in the wrong order, `alloc_ready` falls at the wrong occupancy, or entries that should have been squashed still retire after a redirect. A stale producer table shows up at once on the lookup ports: `busy` stays high after the last writer retires, names an older tag, or survives a flush. A lost or misdirected result write shows up as a retirement that never comes, or as a forwarded value that disagrees with the one later written to the register file.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_REG    = 2'b00,
    K_STORE  = 2'b01,
    K_BRANCH = 2'b10
  } kind_e;
endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             empty,
  output logic             full
);
  logic [PTR_W-1:0] head_q, tail_q, occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      head_q <= tail_q;           // squash everything, tags keep advancing
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign empty    = (head_q == tail_q);
  assign full     = (head_idx == tail_idx) && (head_q[IDX_W] != tail_q[IDX_W]);
  assign occ      = tail_q - head_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_occupancy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PTR_W'(DEPTH));
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DEST_W = 32,
  parameter int DATA_W = 32,
  parameter int NLK    = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  kind_e             wr_kind,
  input  logic [DEST_W-1:0] wr_dest,
  input  logic              res_en,
  input  logic [IDX_W-1:0]  res_idx,
  input  logic [DATA_W-1:0] res_value,
  input  logic              res_mispred,
  input  logic [IDX_W-1:0]  head_idx,
  output kind_e             head_kind,
  output logic [DEST_W-1:0] head_dest,
  output logic [DATA_W-1:0] head_value,
  output logic              head_ready,
  output logic              head_mispred,
  input  logic [IDX_W-1:0]  lk_idx   [NLK],
  output logic              lk_ready [NLK],
  output logic [DATA_W-1:0] lk_value [NLK]
);
  kind_e             kind_q  [DEPTH];
  logic [DEST_W-1:0] dest_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];
  logic [DEPTH-1:0]  ready_q;
  logic [DEPTH-1:0]  misp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= '0;
      misp_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i]  <= K_REG;
        dest_q[i]  <= '0;
        value_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && wr_idx == IDX_W'(i)) begin
          kind_q[i]  <= wr_kind;
          dest_q[i]  <= wr_dest;
          ready_q[i] <= 1'b0;
          misp_q[i]  <= 1'b0;
        end else if (res_en && res_idx == IDX_W'(i)) begin
          value_q[i] <= res_value;
          ready_q[i] <= 1'b1;
          misp_q[i]  <= res_mispred;
        end
      end
    end
  end

  assign head_kind    = kind_q[head_idx];
  assign head_dest    = dest_q[head_idx];
  assign head_value   = value_q[head_idx];
  assign head_ready   = ready_q[head_idx];
  assign head_mispred = misp_q[head_idx];

  for (genvar g = 0; g < NLK; g++) begin : g_lk
    assign lk_ready[g] = ready_q[lk_idx[g]];
    assign lk_value[g] = value_q[lk_idx[g]];
  end
endmodule

// File: rtl/rob_rename_map.sv
module rob_rename_map #(
  parameter int NREG  = 16,
  parameter int DEPTH = 8,
  parameter int NLK   = 2,
  localparam int REG_W = $clog2(NREG),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [IDX_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  input  logic [IDX_W-1:0] clr_tag,
  input  logic [REG_W-1:0] lk_reg  [NLK],
  output logic             lk_busy [NLK],
  output logic [IDX_W-1:0] lk_tag  [NLK]
);
  logic [NREG-1:0]  busy_q;
  logic [IDX_W-1:0] tag_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int r = 0; r < NREG; r++) tag_q[r] <= '0;
    end else if (flush) begin
      busy_q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (set_en && set_reg == REG_W'(r)) begin
          busy_q[r] <= 1'b1;      // a newer producer always wins
          tag_q[r]  <= set_tag;
        end else if (clr_en && clr_reg == REG_W'(r) && tag_q[r] == clr_tag) begin
          busy_q[r] <= 1'b0;      // only the youngest producer clears it
        end
      end
    end
  end

  for (genvar g = 0; g < NLK; g++) begin : g_lk
    assign lk_busy[g] = busy_q[lk_reg[g]];
    assign lk_tag[g]  = tag_q[lk_reg[g]];
  end

  assert_map_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_q == '0));
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NREG   = 16,
  parameter int DEST_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int REG_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [1:0]        alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              res_valid,
  input  logic [IDX_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_value,
  input  logic              res_mispred,
  input  logic [REG_W-1:0]  lk0_reg,
  output logic              lk0_busy,
  output logic [IDX_W-1:0]  lk0_tag,
  output logic              lk0_ready,
  output logic [DATA_W-1:0] lk0_value,
  input  logic [REG_W-1:0]  lk1_reg,
  output logic              lk1_busy,
  output logic [IDX_W-1:0]  lk1_tag,
  output logic              lk1_ready,
  output logic [DATA_W-1:0] lk1_value,
  output logic              cm_reg_we,
  output logic [REG_W-1:0]  cm_reg_idx,
  output logic [DATA_W-1:0] cm_reg_data,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [DEST_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic              redir_valid,
  output logic [DATA_W-1:0] redir_pc
);
  localparam int NLK = 2;

  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic              empty, full, push, pop, flush_now, head_live;
  kind_e             head_kind;
  logic [DEST_W-1:0] head_dest;
  logic [DATA_W-1:0] head_value;
  logic              head_ready, head_mispred;
  logic [REG_W-1:0]  lk_reg_a   [NLK];
  logic              lk_busy_a  [NLK];
  logic [IDX_W-1:0]  lk_tag_a   [NLK];
  logic              lk_ent_rdy [NLK];
  logic [DATA_W-1:0] lk_val_a   [NLK];

  assign head_live   = !empty && head_ready;
  assign flush_now   = head_live && head_kind == K_BRANCH && head_mispred;
  assign alloc_ready = !full && !flush_now;
  assign push        = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_idx;
  assign pop         = head_live && (head_kind != K_STORE || st_ready);

  assign cm_reg_we   = head_live && head_kind == K_REG;
  assign cm_reg_idx  = head_dest[REG_W-1:0];
  assign cm_reg_data = head_value;
  assign st_valid    = head_live && head_kind == K_STORE;
  assign st_addr     = head_dest;
  assign st_data     = head_value;
  assign redir_valid = flush_now;
  assign redir_pc    = head_value;

  rob_ptr_ctl #(.DEPTH(DEPTH)) ptr_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush_now),
    .head_idx(head_idx), .tail_idx(tail_idx), .empty(empty), .full(full)
  );

  rob_entry_array #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W), .NLK(NLK)) ent_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push), .wr_idx(tail_idx), .wr_kind(kind_e'(alloc_kind)), .wr_dest(alloc_dest),
    .res_en(res_valid), .res_idx(res_tag), .res_value(res_value), .res_mispred(res_mispred),
    .head_idx(head_idx), .head_kind(head_kind), .head_dest(head_dest),
    .head_value(head_value), .head_ready(head_ready), .head_mispred(head_mispred),
    .lk_idx(lk_tag_a), .lk_ready(lk_ent_rdy), .lk_value(lk_val_a)
  );

  rob_rename_map #(.NREG(NREG), .DEPTH(DEPTH), .NLK(NLK)) map_i (
    .clk(clk), .rst_n(rst_n), .flush(flush_now),
    .set_en(push && kind_e'(alloc_kind) == K_REG), .set_reg(alloc_dest[REG_W-1:0]),
    .set_tag(tail_idx),
    .clr_en(cm_reg_we), .clr_reg(cm_reg_idx), .clr_tag(head_idx),
    .lk_reg(lk_reg_a), .lk_busy(lk_busy_a), .lk_tag(lk_tag_a)
  );

  assign lk_reg_a[0] = lk0_reg;
  assign lk_reg_a[1] = lk1_reg;
  assign lk0_busy    = lk_busy_a[0];
  assign lk0_tag     = lk_tag_a[0];
  assign lk0_ready   = lk_busy_a[0] && lk_ent_rdy[0];
  assign lk0_value   = lk_val_a[0];
  assign lk1_busy    = lk_busy_a[1];
  assign lk1_tag     = lk_tag_a[1];
  assign lk1_ready   = lk_busy_a[1] && lk_ent_rdy[1];
  assign lk1_value   = lk_val_a[1];

  assert_store_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_addr) && $stable(st_data));
  assert_commit_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !empty && res_tag == head_idx |-> !(cm_reg_we || st_valid || redir_valid));
  assert_redirect_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid && !cm_reg_we && !st_valid);
endmodule

// File: tb/rob_core_tb_top.sv
module rob_core_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid, alloc_ready;
  logic [1:0]  alloc_kind;
  logic [31:0] alloc_dest;
  logic [2:0]  alloc_tag;
  logic        res_valid, res_mispred;
  logic [2:0]  res_tag;
  logic [31:0] res_value;
  logic [3:0]  lk0_reg, lk1_reg, cm_reg_idx;
  logic        lk0_busy, lk0_ready, lk1_busy, lk1_ready;
  logic [2:0]  lk0_tag, lk1_tag;
  logic [31:0] lk0_value, lk1_value, cm_reg_data, st_addr, st_data, redir_pc;
  logic        cm_reg_we, st_valid, st_ready, redir_valid;

  always #2 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .NREG(16), .DEST_W(32), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_tag(alloc_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value), .res_mispred(res_mispred),
    .lk0_reg(lk0_reg), .lk0_busy(lk0_busy), .lk0_tag(lk0_tag), .lk0_ready(lk0_ready),
    .lk0_value(lk0_value),
    .lk1_reg(lk1_reg), .lk1_busy(lk1_busy), .lk1_tag(lk1_tag), .lk1_ready(lk1_ready),
    .lk1_value(lk1_value),
    .cm_reg_we(cm_reg_we), .cm_reg_idx(cm_reg_idx), .cm_reg_data(cm_reg_data),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  int          n_chk = 0, n_fail = 0;
  bit          done = 0;
  logic [2:0]  exp_tag = '0;
  int          n_cm = 0, n_redir = 0, n_st = 0;
  logic [3:0]  cm_reg_log [0:63];
  logic [31:0] cm_dat_log [0:63];
  logic [31:0] last_redir;

  // retirement monitor, sampled between edges
  always @(negedge clk) begin
    #1;
    if (rst_n && cm_reg_we && n_cm < 64) begin
      cm_reg_log[n_cm] = cm_reg_idx;
      cm_dat_log[n_cm] = cm_reg_data;
      n_cm++;
    end
    if (rst_n && redir_valid) begin
      n_redir++;
      last_redir = redir_pc;
    end
    if (rst_n && st_valid && st_ready) n_st++;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic alloc(input logic [1:0] k, input logic [31:0] d, output logic [2:0] t);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_kind = k; alloc_dest = d;
    #1;
    chk("R2 alloc_ready", 32'(alloc_ready), 32'd1);
    chk("R2 tag order", 32'(alloc_tag), 32'(exp_tag));
    t = alloc_tag;
    exp_tag = exp_tag + 3'd1;
    @(posedge clk); #1;
    alloc_valid = 1'b0;
  endtask

  task automatic result(input logic [2:0] t, input logic [31:0] v, input logic m);
    @(negedge clk);
    res_valid = 1'b1; res_tag = t; res_value = v; res_mispred = m;
    @(posedge clk); #1;
    res_valid = 1'b0; res_mispred = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk); #1;
    chk("R1 alloc_ready", 32'(alloc_ready), 32'd1);
    chk("R1 cm_reg_we", 32'(cm_reg_we), 32'd0);
    chk("R1 st_valid", 32'(st_valid), 32'd0);
    chk("R1 redir_valid", 32'(redir_valid), 32'd0);
    chk("R1 lk0_busy", 32'(lk0_busy), 32'd0);
    chk("R1 lk1_busy", 32'(lk1_busy), 32'd0);
  endtask

  task automatic test_out_of_order();
    logic [2:0] t [4];
    int base = n_cm;
    for (int i = 0; i < 4; i++) alloc(2'b00, 32'(i + 1), t[i]);
    result(t[2], 32'h33, 1'b0);
    @(negedge clk);
    lk0_reg = 4'd3; lk1_reg = 4'd1;
    #1;
    chk("R6 busy pending", 32'(lk0_busy), 32'd1);
    chk("R6 tag", 32'(lk0_tag), 32'(t[2]));
    chk("R6 forwarded ready", 32'(lk0_ready), 32'd1);
    chk("R6 forwarded value", lk0_value, 32'h33);
    chk("R6 busy not ready", 32'(lk1_busy), 32'd1);
    chk("R6 not ready", 32'(lk1_ready), 32'd0);
    chk("R5 no early retire", 32'(n_cm - base), 32'd0);
    result(t[3], 32'h44, 1'b0);
    result(t[1], 32'h22, 1'b0);
    chk("R4 head incomplete holds", 32'(n_cm - base), 32'd0);
    result(t[0], 32'h11, 1'b0);
    idle(6);
    chk("R5 count", 32'(n_cm - base), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R5 order reg", 32'(cm_reg_log[base + i]), 32'(i + 1));
      chk("R4 value", cm_dat_log[base + i], 32'(8'h11 * (i + 1)));
    end
    lk0_reg = 4'd1; #1;
    chk("R7 released", 32'(lk0_busy), 32'd0);
  endtask

  task automatic test_two_producers();
    logic [2:0] ta, tb;
    alloc(2'b00, 32'd5, ta);
    alloc(2'b00, 32'd5, tb);
    result(ta, 32'h55, 1'b0);
    idle(3);
    lk0_reg = 4'd5; #1;
    chk("R7 younger still busy", 32'(lk0_busy), 32'd1);
    chk("R7 younger tag", 32'(lk0_tag), 32'(tb));
    result(tb, 32'h56, 1'b0);
    idle(3);
    lk0_reg = 4'd5; #1;
    chk("R7 cleared by youngest", 32'(lk0_busy), 32'd0);
    chk("R5 last value", cm_dat_log[n_cm - 1], 32'h56);
  endtask

  task automatic test_full();
    logic [2:0] t [DEPTH];
    int base = n_cm;
    for (int i = 0; i < DEPTH; i++) alloc(2'b00, 32'(i + 1), t[i]);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_kind = 2'b00; alloc_dest = 32'd15; lk0_reg = 4'd15;
    #1;
    chk("R3 full stalls", 32'(alloc_ready), 32'd0);
    idle(2);
    alloc_valid = 1'b0;
    #1;
    chk("R3 ignored alloc leaves map", 32'(lk0_busy), 32'd0);
    for (int i = DEPTH - 1; i >= 0; i--) result(t[i], 32'h100 + 32'(i), 1'b0);
    idle(12);
    chk("R3 only DEPTH retired", 32'(n_cm - base), 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      chk("R5 full order reg", 32'(cm_reg_log[base + i]), 32'(i + 1));
      chk("R5 full order data", cm_dat_log[base + i], 32'h100 + 32'(i));
    end
  endtask

  task automatic test_store();
    logic [2:0] ts, tr;
    int base = n_cm;
    int sbase = n_st;
    alloc(2'b01, 32'h1000, ts);
    alloc(2'b00, 32'd6, tr);
    result(tr, 32'h66, 1'b0);
    result(ts, 32'hABCD, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R8 store offered", 32'(st_valid), 32'd1);
      chk("R8 store addr", st_addr, 32'h1000);
      chk("R8 store data", st_data, 32'hABCD);
      chk("R8 younger blocked", 32'(cm_reg_we), 32'd0);
    end
    @(negedge clk);
    st_ready = 1'b1;
    @(posedge clk); #1;
    st_ready = 1'b0;
    idle(3);
    chk("R8 store accepted once", 32'(n_st - sbase), 32'd1);
    chk("R8 younger retires after", 32'(n_cm - base), 32'd1);
    chk("R8 younger reg", 32'(cm_reg_log[n_cm - 1]), 32'd6);
  endtask

  task automatic test_good_branch();
    logic [2:0] tb, tr;
    int rbase = n_redir;
    alloc(2'b10, 32'd0, tb);
    alloc(2'b00, 32'd7, tr);
    result(tb, 32'h200, 1'b0);
    result(tr, 32'h77, 1'b0);
    idle(4);
    chk("R9 no redirect", 32'(n_redir - rbase), 32'd0);
    chk("R9 following reg retires", 32'(cm_reg_log[n_cm - 1]), 32'd7);
    chk("R9 following value", cm_dat_log[n_cm - 1], 32'h77);
  endtask

  task automatic test_mispredict();
    logic [2:0] t0, t1, t2, t3, tn;
    int base = n_cm;
    alloc(2'b00, 32'd8, t0);
    alloc(2'b10, 32'd0, t1);
    alloc(2'b00, 32'd9, t2);
    alloc(2'b00, 32'd10, t3);
    result(t2, 32'h99, 1'b0);
    result(t3, 32'hAA, 1'b0);
    result(t1, 32'h400, 1'b1);
    result(t0, 32'h88, 1'b0);
    @(negedge clk); #1;
    chk("R10 older retires first", 32'(cm_reg_we), 32'd1);
    chk("R10 older reg", 32'(cm_reg_idx), 32'd8);
    @(negedge clk); #1;
    chk("R10 redirect", 32'(redir_valid), 32'd1);
    chk("R10 redirect pc", redir_pc, 32'h400);
    chk("R10 alloc held", 32'(alloc_ready), 32'd0);
    @(negedge clk);
    lk0_reg = 4'd9; lk1_reg = 4'd10;
    #1;
    chk("R10 single pulse", 32'(redir_valid), 32'd0);
    chk("R10 empty accepts", 32'(alloc_ready), 32'd1);
    chk("R10 map cleared 9", 32'(lk0_busy), 32'd0);
    chk("R10 map cleared 10", 32'(lk1_busy), 32'd0);
    idle(3);
    chk("R10 younger squashed", 32'(n_cm - base), 32'd1);
    alloc(2'b00, 32'd11, tn);
    result(tn, 32'hBB, 1'b0);
    idle(3);
    chk("R10 restart retires", 32'(cm_reg_log[n_cm - 1]), 32'd11);
    chk("R10 restart value", cm_dat_log[n_cm - 1], 32'hBB);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    alloc_valid = 1'b0; alloc_kind = 2'b00; alloc_dest = '0;
    res_valid = 1'b0; res_tag = '0; res_value = '0; res_mispred = 1'b0;
    lk0_reg = '0; lk1_reg = '0; st_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_out_of_order();
    test_two_producers();
    test_full();
    test_store();
    test_good_branch();
    test_mispredict();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule